// File: doc/BRIEF.md
# Receive Frame Buffer Writer

This block takes one incoming Ethernet frame at a time as a byte stream and lays it into a packet buffer in a fixed layout. The buffer holds, in address order: a 16-bit status word, a 16-bit byte count, the payload, zero padding up to 64 payload bytes for short frames, an optional CRC32 and a two-byte trailer. The block computes the CRC and the status flags on the fly. After the last byte is written, it pushes the buffer number to the receive queue and raises the receive interrupt.

The first beat of a frame carries its declared length. While that beat waits, the block decides whether to accept the frame. A frame is rejected when reception is disabled, when soft reset is held, when its length is zero or when it does not fit in a buffer. An accepted frame asks an external allocator for a buffer, and the allocator answers with a buffer number or a failure. A rejected frame, or one that fails allocation, is consumed from the stream up to its last beat and reported with a drop pulse. Each frame ends in exactly one done pulse or one drop pulse.

The byte stream uses valid/ready. A beat moves on a clock edge where both are high. The source must hold its data, flags and length stable while valid is high and ready is low. Ready is low while the frame is being decided, while a buffer is being granted, while the header is written and while padding, CRC and trailer bytes are written. The last flag must come on the beat whose index equals the declared length minus one.

Top module: `rx_frame_writer`

## Requirements
- R1: When receive-enable is low or soft reset is high on the first beat, the frame is consumed up to its last beat. No buffer write and no queue push happen, and frame_drop pulses for one cycle.
- R2: The byte count is (length rounded down to even, or 64 if length < 64) + 6, plus 4 when CRC is kept. A frame whose count exceeds BUF_BYTES (2048), or whose length is 0, is dropped as in R1.
- R3: Bytes 0 and 1 hold the status word, low byte first. Bit 11 is set when the length exceeds 1518, bit 12 is set when the length is odd, and all other bits are 0.
- R4: Bytes 2 and 3 hold the byte count, low byte first. The even part of the payload follows from byte 4 in stream order.
- R5: For a frame shorter than 64 bytes, the odd last byte (if any) is written inline after the even part, and zeros then fill the payload area up to 64 bytes.
- R6: When cfg_strip_crc is low, a CRC32 follows the payload area, least significant byte first. It uses the reflected polynomial 0xEDB88320, an all-ones start value and no final inversion. It covers every payload byte, including the odd byte and any zero padding.
- R7: The last two bytes are the odd last byte then 0x60 for an odd length, or 0x00 then 0x40 for an even length. This holds for short frames too. For a frame of 64 bytes or more, the odd byte appears only in the trailer.
- R8: In the cycle after the last trailer write, rxq_push, rx_int_set and frame_done pulse together for one cycle, and rxq_num is the granted buffer number.
- R9: alloc_req stays high until alloc_gnt. A grant with alloc_fail high drops the frame as in R1. A grant without it selects buffer alloc_num for every write of the frame.
- R10: An accepted frame writes exactly as many bytes as its count, at consecutive addresses starting at 0.
- R11: s_ready is low in every cycle where alloc_req is high, so no beat is taken before the frame is decided and granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_rx_en | input | 1 | Receive enable, sampled on the first beat |
| cfg_soft_rst | input | 1 | Soft reset active, sampled on the first beat |
| cfg_strip_crc | input | 1 | Omit the CRC from the buffer |
| s_valid | input | 1 | Stream beat valid |
| s_ready | output | 1 | Stream beat accepted when high with s_valid |
| s_data | input | 8 | Stream byte |
| s_first | input | 1 | First beat of a frame |
| s_last | input | 1 | Last beat of a frame |
| s_len | input | LEN_W | Declared frame length, valid with the first beat |
| alloc_req | output | 1 | Buffer request pending |
| alloc_gnt | input | 1 | Allocator answer valid |
| alloc_fail | input | 1 | No buffer available |
| alloc_num | input | BN_W | Granted buffer number |
| wr_en | output | 1 | Buffer write strobe |
| wr_buf | output | BN_W | Buffer number of the write |
| wr_addr | output | AW | Byte address inside the buffer |
| wr_data | output | 8 | Byte written |
| rxq_push | output | 1 | Push to the receive queue |
| rxq_num | output | BN_W | Buffer number pushed |
| rx_int_set | output | 1 | Set the receive interrupt |
| frame_done | output | 1 | Frame stored |
| frame_drop | output | 1 | Frame discarded |

## Verification
The bench targets the length edges: 1, 63, 64 and 65 bytes, lengths around 1518, and the largest frames that just fit or just miss 2048 with and without the CRC. A sizing error at these edges shows up as a wrong count field, a missing or extra pad byte, or a frame dropped when it should be kept. Odd lengths are checked both short and long. A design that mixed up the two odd-byte placements would repeat the byte inline in long frames, or leave it out of the short-frame padding and so of the CRC. Allocation failure, receive disabled and soft reset must each leave the buffer untouched while still draining the stream. A sequencer that took a beat during the grant wait would shift the whole payload by one byte.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ALLOC,
    ST_DRAIN,
    ST_DROP,
    ST_HDR,
    ST_PAY,
    ST_PAD,
    ST_CRC,
    ST_TRL,
    ST_FIN
  } rxw_state_e;

  localparam int STAT_LONG_BIT = 11;
  localparam int STAT_ODD_BIT  = 12;
  localparam int HDR_BYTES     = 4;
  localparam int TRL_BYTES     = 2;
  localparam int CRC_BYTES     = 4;

  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam logic [31:0] CRC_INIT = 32'hFFFFFFFF;

  localparam logic [7:0] TRL_ODD_MARK  = 8'h60;
  localparam logic [7:0] TRL_EVEN_MARK = 8'h40;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 8; b++) begin
      if (r[0] ^ d[b]) r = (r >> 1) ^ CRC_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/rxw_sizer.sv
module rxw_sizer #(
  parameter int LEN_W      = 12,
  parameter int BUF_BYTES  = 2048,
  parameter int MIN_FRAME  = 64,
  parameter int LONG_LIMIT = 1518,
  localparam int CNT_W     = LEN_W + 1
) (
  input  logic [LEN_W-1:0] len,
  input  logic             rx_en,
  input  logic             soft_rst,
  input  logic             strip_crc,
  output logic             accept,
  output logic [CNT_W-1:0] count,
  output logic [15:0]      status,
  output logic             odd,
  output logic             short_fr,
  output logic             keep
);
  import rxw_pkg::*;

  localparam logic [CNT_W-1:0] MIN_C   = CNT_W'(MIN_FRAME);
  localparam logic [CNT_W-1:0] OVH_C   = CNT_W'(HDR_BYTES + TRL_BYTES);
  localparam logic [CNT_W-1:0] CRC_C   = CNT_W'(CRC_BYTES);
  localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(BUF_BYTES);

  logic [CNT_W-1:0] even_part;
  logic [CNT_W-1:0] base;

  always_comb begin
    even_part = {1'b0, len[LEN_W-1:1], 1'b0};
    short_fr  = (CNT_W'(len) < MIN_C);
    odd       = len[0];
    keep      = !strip_crc;
    base      = short_fr ? MIN_C : even_part;
    count     = base + OVH_C + (keep ? CRC_C : '0);
    accept    = rx_en && !soft_rst && (len != '0) && (count <= LIMIT_C);
    status    = '0;
    status[STAT_LONG_BIT] = (CNT_W'(len) > CNT_W'(LONG_LIMIT));
    status[STAT_ODD_BIT]  = len[0];
  end

endmodule

// File: rtl/rxw_crc.sv
module rxw_crc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc
);
  import rxw_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc <= CRC_INIT;
    else if (clr) crc <= CRC_INIT;
    else if (en)  crc <= crc_step(crc, din);
  end

endmodule

// File: rtl/rxw_seq.sv
module rxw_seq #(
  parameter int LEN_W     = 12,
  parameter int BN_W      = 2,
  parameter int AW        = 11,
  parameter int MIN_FRAME = 64,
  localparam int CNT_W    = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [7:0]       s_data,
  input  logic             s_first,
  input  logic             s_last,
  input  logic [LEN_W-1:0] s_len,
  input  logic             sz_accept,
  input  logic [CNT_W-1:0] sz_count,
  input  logic [15:0]      sz_status,
  input  logic             sz_odd,
  input  logic             sz_short,
  input  logic             sz_keep,
  output logic             alloc_req,
  input  logic             alloc_gnt,
  input  logic             alloc_fail,
  input  logic [BN_W-1:0]  alloc_num,
  input  logic [31:0]      crc_val,
  output logic             crc_clr,
  output logic             crc_en,
  output logic [7:0]       crc_din,
  output logic             wr_en,
  output logic [BN_W-1:0]  wr_buf,
  output logic [AW-1:0]    wr_addr,
  output logic [7:0]       wr_data,
  output logic             rxq_push,
  output logic [BN_W-1:0]  rxq_num,
  output logic             rx_int_set,
  output logic             frame_done,
  output logic             frame_drop
);
  import rxw_pkg::*;

  localparam logic [LEN_W-1:0] PAD_END = LEN_W'(MIN_FRAME - 1);

  rxw_state_e       state_q, state_d;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] pos_q;
  logic [15:0]      status_q;
  logic [15:0]      count_q;
  logic             odd_q, short_q, keep_q;
  logic [BN_W-1:0]  buf_q;
  logic [AW-1:0]    addr_q;
  logic [1:0]       idx_q;
  logic [7:0]       odd_byte_q;

  logic beat;
  logic last_pos;
  logic hold_odd;

  assign s_ready   = (state_q == ST_PAY) || (state_q == ST_DRAIN);
  assign beat      = s_valid && s_ready;
  assign last_pos  = (pos_q == len_q - LEN_W'(1));
  assign hold_odd  = last_pos && odd_q && !short_q;
  assign alloc_req = (state_q == ST_ALLOC);
  assign crc_clr   = (state_q == ST_IDLE);

  assign wr_buf     = buf_q;
  assign wr_addr    = addr_q;
  assign rxq_num    = buf_q;
  assign rxq_push   = (state_q == ST_FIN);
  assign rx_int_set = (state_q == ST_FIN);
  assign frame_done = (state_q == ST_FIN);
  assign frame_drop = (state_q == ST_DROP);

  // write port and CRC feed
  always_comb begin
    wr_en   = 1'b0;
    wr_data = 8'h00;
    crc_en  = 1'b0;
    crc_din = 8'h00;
    unique case (state_q)
      ST_HDR: begin
        wr_en = 1'b1;
        unique case (idx_q)
          2'd0: wr_data = status_q[7:0];
          2'd1: wr_data = status_q[15:8];
          2'd2: wr_data = count_q[7:0];
          default: wr_data = count_q[15:8];
        endcase
      end
      ST_PAY: begin
        wr_en   = beat && !hold_odd;
        wr_data = s_data;
        crc_en  = beat;
        crc_din = s_data;
      end
      ST_PAD: begin
        wr_en  = 1'b1;
        crc_en = 1'b1;
      end
      ST_CRC: begin
        wr_en   = 1'b1;
        wr_data = crc_val[8*idx_q +: 8];
      end
      ST_TRL: begin
        wr_en = 1'b1;
        if (idx_q == 2'd0) wr_data = odd_q ? odd_byte_q : 8'h00;
        else               wr_data = odd_q ? TRL_ODD_MARK : TRL_EVEN_MARK;
      end
      default: ;
    endcase
  end

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (s_valid && s_first) state_d = sz_accept ? ST_ALLOC : ST_DRAIN;
      ST_ALLOC: if (alloc_gnt) state_d = alloc_fail ? ST_DRAIN : ST_HDR;
      ST_DRAIN: if (beat && s_last) state_d = ST_DROP;
      ST_DROP:  state_d = ST_IDLE;
      ST_HDR:   if (idx_q == 2'd3) state_d = ST_PAY;
      ST_PAY: begin
        if (beat && last_pos) begin
          if (short_q)     state_d = ST_PAD;
          else if (keep_q) state_d = ST_CRC;
          else             state_d = ST_TRL;
        end
      end
      ST_PAD:   if (pos_q == PAD_END) state_d = keep_q ? ST_CRC : ST_TRL;
      ST_CRC:   if (idx_q == 2'd3) state_d = ST_TRL;
      ST_TRL:   if (idx_q == 2'd1) state_d = ST_FIN;
      ST_FIN:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      len_q      <= '0;
      pos_q      <= '0;
      status_q   <= '0;
      count_q    <= '0;
      odd_q      <= 1'b0;
      short_q    <= 1'b0;
      keep_q     <= 1'b0;
      buf_q      <= '0;
      addr_q     <= '0;
      idx_q      <= '0;
      odd_byte_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && s_valid && s_first) begin
        len_q    <= s_len;
        status_q <= sz_status;
        count_q  <= 16'(sz_count);
        odd_q    <= sz_odd;
        short_q  <= sz_short;
        keep_q   <= sz_keep;
      end
      if (state_q == ST_ALLOC && alloc_gnt && !alloc_fail) begin
        buf_q  <= alloc_num;
        addr_q <= '0;
        idx_q  <= '0;
        pos_q  <= '0;
      end else if (wr_en) begin
        addr_q <= addr_q + AW'(1);
      end
      if (state_q == ST_HDR || state_q == ST_CRC || state_q == ST_TRL) begin
        idx_q <= (state_d == state_q) ? idx_q + 2'd1 : 2'd0;
      end
      if ((state_q == ST_PAY && beat) || state_q == ST_PAD) begin
        pos_q <= pos_q + LEN_W'(1);
      end
      if (state_q == ST_PAY && beat && last_pos) begin
        odd_byte_q <= s_data;
        idx_q      <= 2'd0;
      end
    end
  end

endmodule

// File: rtl/rx_frame_writer.sv
module rx_frame_writer #(
  parameter int LEN_W      = 12,
  parameter int BN_W       = 2,
  parameter int BUF_BYTES  = 2048,
  parameter int MIN_FRAME  = 64,
  parameter int LONG_LIMIT = 1518,
  localparam int AW        = $clog2(BUF_BYTES),
  localparam int CNT_W     = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_rx_en,
  input  logic             cfg_soft_rst,
  input  logic             cfg_strip_crc,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [7:0]       s_data,
  input  logic             s_first,
  input  logic             s_last,
  input  logic [LEN_W-1:0] s_len,
  output logic             alloc_req,
  input  logic             alloc_gnt,
  input  logic             alloc_fail,
  input  logic [BN_W-1:0]  alloc_num,
  output logic             wr_en,
  output logic [BN_W-1:0]  wr_buf,
  output logic [AW-1:0]    wr_addr,
  output logic [7:0]       wr_data,
  output logic             rxq_push,
  output logic [BN_W-1:0]  rxq_num,
  output logic             rx_int_set,
  output logic             frame_done,
  output logic             frame_drop
);

  logic             sz_accept, sz_odd, sz_short, sz_keep;
  logic [CNT_W-1:0] sz_count;
  logic [15:0]      sz_status;
  logic [31:0]      crc_val;
  logic             crc_clr, crc_en;
  logic [7:0]       crc_din;

  rxw_sizer #(
    .LEN_W(LEN_W), .BUF_BYTES(BUF_BYTES),
    .MIN_FRAME(MIN_FRAME), .LONG_LIMIT(LONG_LIMIT)
  ) u_sizer (
    .len(s_len), .rx_en(cfg_rx_en), .soft_rst(cfg_soft_rst),
    .strip_crc(cfg_strip_crc), .accept(sz_accept), .count(sz_count),
    .status(sz_status), .odd(sz_odd), .short_fr(sz_short), .keep(sz_keep)
  );

  rxw_crc u_crc (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en),
    .din(crc_din), .crc(crc_val)
  );

  rxw_seq #(
    .LEN_W(LEN_W), .BN_W(BN_W), .AW(AW), .MIN_FRAME(MIN_FRAME)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_first(s_first), .s_last(s_last), .s_len(s_len),
    .sz_accept(sz_accept), .sz_count(sz_count), .sz_status(sz_status),
    .sz_odd(sz_odd), .sz_short(sz_short), .sz_keep(sz_keep),
    .alloc_req(alloc_req), .alloc_gnt(alloc_gnt), .alloc_fail(alloc_fail),
    .alloc_num(alloc_num),
    .crc_val(crc_val), .crc_clr(crc_clr), .crc_en(crc_en), .crc_din(crc_din),
    .wr_en(wr_en), .wr_buf(wr_buf), .wr_addr(wr_addr), .wr_data(wr_data),
    .rxq_push(rxq_push), .rxq_num(rxq_num), .rx_int_set(rx_int_set),
    .frame_done(frame_done), .frame_drop(frame_drop)
  );

endmodule

// File: rtl/rxw_checker.sv
module rxw_checker #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_ready,
  input logic          alloc_req,
  input logic          alloc_gnt,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [7:0]    wr_data,
  input logic          frame_done,
  input logic          frame_drop
);

  logic wrote_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         wrote_q <= 1'b0;
    else if (frame_done || frame_drop)  wrote_q <= 1'b0;
    else if (wr_en)                     wrote_q <= 1'b1;
  end

  p_drop_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_drop |-> (!wrote_q && !wr_en));

  p_status_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == '0) |-> (wr_data == 8'h00));

  p_status_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(1)) |-> (wr_data[7:5] == 3'b000 && wr_data[2:0] == 3'b000));

  p_trailer_mark_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> ($past(wr_en) && ($past(wr_data) == 8'h60 || $past(wr_data) == 8'h40)));

  p_alloc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && !alloc_gnt) |=> alloc_req);

  p_addr_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + AW'(1)));

  p_no_beat_in_alloc_r11: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req |-> !s_ready);

  p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_done && frame_drop));

endmodule

bind rx_frame_writer rxw_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_ready(s_ready), .alloc_req(alloc_req),
  .alloc_gnt(alloc_gnt), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .frame_done(frame_done), .frame_drop(frame_drop)
);

// File: tb/rx_frame_writer_test.sv
module rx_frame_writer_test;
  localparam int LEN_W = 12;
  localparam int BN_W  = 2;
  localparam int AW    = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_rx_en = 1'b0, cfg_soft_rst = 1'b0, cfg_strip_crc = 1'b0;
  logic s_valid = 1'b0, s_first = 1'b0, s_last = 1'b0;
  logic [7:0] s_data = '0;
  logic [LEN_W-1:0] s_len = '0;
  logic s_ready;
  logic alloc_req;
  logic alloc_gnt = 1'b0, alloc_fail = 1'b0;
  logic [BN_W-1:0] alloc_num = '0;
  logic wr_en;
  logic [BN_W-1:0] wr_buf;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_data;
  logic rxq_push, rx_int_set, frame_done, frame_drop;
  logic [BN_W-1:0] rxq_num;

  rx_frame_writer uut (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  logic [7:0] pl [0:4095];
  logic [7:0] expb [0:2047];
  logic [7:0] mem [0:2047];
  int nwr;
  bit got_done, got_drop, push_seen, irq_seen, buf_bad;
  logic [BN_W-1:0] push_num;
  bit next_fail;
  logic [BN_W-1:0] next_buf;
  int wcnt = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_upd(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r = c;
    for (int b = 0; b < 8; b++) r = (r[0] != d[b]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  // builds expected buffer image, returns byte count
  function automatic int build_exp(input int len, input bit keep);
    int k, ev, cnt, span;
    logic [31:0] c;
    logic [15:0] st;
    bit sh;
    sh = len < 64;
    ev = len & ~1;
    cnt = (sh ? 64 : ev) + 6 + (keep ? 4 : 0);
    st = '0;
    st[11] = len > 1518;
    st[12] = len[0];
    expb[0] = st[7:0]; expb[1] = st[15:8];
    expb[2] = cnt[7:0]; expb[3] = cnt[15:8];
    k = 4;
    for (int i = 0; i < ev; i++) begin expb[k] = pl[i]; k++; end
    if (sh) begin
      if (len[0]) begin expb[k] = pl[len-1]; k++; end
      while (k < 68) begin expb[k] = 8'h00; k++; end
    end
    span = sh ? 64 : len;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < span; i++) c = crc_upd(c, (i < len) ? pl[i] : 8'h00);
    if (keep) for (int b = 0; b < 4; b++) begin expb[k] = c[8*b +: 8]; k++; end
    if (k + 2 <= 2048) begin
      expb[k]   = len[0] ? pl[len-1] : 8'h00;
      expb[k+1] = len[0] ? 8'h60 : 8'h40;
    end
    return cnt;
  endfunction

  // monitor: sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_en) begin
        mem[wr_addr] = wr_data;
        nwr++;
        if (wr_buf != next_buf) buf_bad = 1;
      end
      if (frame_done) got_done = 1;
      if (frame_drop) got_drop = 1;
      if (rxq_push) begin push_seen = 1; push_num = rxq_num; end
      if (rx_int_set) irq_seen = 1;
    end
  end

  // allocator model with a two-cycle answer delay
  initial begin
    forever begin
      @(posedge clk); #1;
      if (alloc_gnt) alloc_gnt = 0;
      else if (alloc_req) begin
        check(!s_ready, "R11 ready low while awaiting grant", s_ready, 0);
        if (wcnt >= 2) begin
          alloc_gnt = 1; alloc_fail = next_fail; alloc_num = next_buf; wcnt = 0;
        end else wcnt++;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  task automatic run_frame(input int len, input bit en, input bit srst, input bit strip,
                           input bit afail, input int gap, input string tag);
    int cnt, nb, bad, first_bad;
    bit expect_ok, acc;
    for (int i = 0; i < len; i++) pl[i] = 8'($urandom);
    cnt = build_exp(len, !strip);
    expect_ok = en && !srst && len > 0 && cnt <= 2048 && !afail;
    for (int i = 0; i < 2048; i++) mem[i] = 8'hEE;
    nwr = 0; got_done = 0; got_drop = 0; push_seen = 0; irq_seen = 0; buf_bad = 0;
    next_fail = afail; next_buf = BN_W'($urandom);
    cfg_rx_en = en; cfg_soft_rst = srst; cfg_strip_crc = strip;
    nb = (len == 0) ? 1 : len;
    for (int i = 0; i < nb; i++) begin
      if (gap > 0 && ($urandom % 100) < gap) begin
        s_valid = 0; @(posedge clk); #1;
      end
      s_valid = 1; s_data = (len == 0) ? 8'h00 : pl[i];
      s_first = (i == 0); s_last = (i == nb - 1); s_len = LEN_W'(len);
      do begin
        @(negedge clk); acc = s_ready;
        @(posedge clk); #1;
      end while (!acc);
    end
    s_valid = 0; s_first = 0; s_last = 0;
    for (int t = 0; t < 200 && !got_done && !got_drop; t++) @(negedge clk);
    @(posedge clk); #1;
    if (expect_ok) begin
      check(got_done && !got_drop, {tag, " R8 done pulse"}, got_done, 1);
      check(push_seen && irq_seen && push_num == next_buf, {tag, " R8 push/irq/num"}, push_num, next_buf);
      check(nwr == cnt, {tag, " R10 bytes written"}, nwr, cnt);
      check(!buf_bad, {tag, " R9 write buffer"}, buf_bad, 0);
      bad = 0; first_bad = -1;
      for (int i = 0; i < cnt; i++) if (mem[i] !== expb[i]) begin
        bad++; if (first_bad < 0) first_bad = i;
      end
      check(bad == 0, {tag, " R3 R4 R5 R6 R7 layout"}, (first_bad < 0) ? 0 : int'(mem[first_bad]),
            (first_bad < 0) ? 0 : int'(expb[first_bad]));
    end else begin
      check(got_drop && !got_done, {tag, " R1 R2 R9 drop pulse"}, got_drop, 1);
      check(nwr == 0 && !push_seen, {tag, " R1 no write or push"}, nwr, 0);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1;
    check(!s_ready && !alloc_req && !wr_en && !frame_done && !frame_drop, "reset outputs", s_ready, 0);
    rst_n = 1;
    @(posedge clk); #1;
    run_frame(1,    1, 0, 0, 0, 0,  "R5 len1");
    run_frame(63,   1, 0, 0, 0, 20, "R5 len63");
    run_frame(64,   1, 0, 0, 0, 0,  "R4 len64");
    run_frame(65,   1, 0, 0, 0, 30, "R7 len65");
    run_frame(60,   1, 0, 1, 0, 0,  "R6 strip short");
    run_frame(1518, 1, 0, 0, 0, 0,  "R3 len1518");
    run_frame(1519, 1, 0, 1, 0, 0,  "R3 len1519");
    run_frame(2038, 1, 0, 0, 0, 0,  "R2 fit crc");
    run_frame(2039, 1, 0, 0, 0, 0,  "R2 fit odd");
    run_frame(2040, 1, 0, 0, 0, 0,  "R2 too big");
    run_frame(2040, 1, 0, 1, 0, 0,  "R2 fit strip");
    run_frame(2044, 1, 0, 1, 0, 0,  "R2 too big strip");
    run_frame(0,    1, 0, 0, 0, 0,  "R2 len0");
    run_frame(100,  0, 0, 0, 0, 10, "R1 disabled");
    run_frame(100,  1, 1, 0, 0, 10, "R1 soft reset");
    run_frame(80,   1, 0, 0, 1, 10, "R9 alloc fail");
    run_frame(71,   1, 0, 0, 0, 0,  "R9 after fail");
    for (int n = 0; n < 24; n++) begin
      run_frame(1 + int'($urandom % 300), ($urandom % 8) != 0, 0, $urandom % 2,
                ($urandom % 6) == 0, 25, "random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule